// File: doc/BRIEF.md
# Indexed Color Palette Loader

This block keeps a color lookup table for an 8-bit indexed display: one 8-bit red, green and blue value for each of 256 entries. A processor programs the table through two byte-addressed registers. One holds the entry pointer. The other accepts color bytes. A small phase counter assigns each incoming color byte to red, then green, then blue. After the blue byte it moves the pointer to the next entry. A 32-bit store to the color register counts as four color bytes in a row, taken from the most significant byte down.

The display side reads the table through an independent scanout port. It presents an 8-bit pixel index and gets the 24-bit color one clock later. Every store to the color register raises a redraw request so that the display side knows the whole frame must be repainted. The display side clears the request with a one-cycle acknowledge.

Top module: `palette_loader`

## Requirements
- R1: A store to offset 0x0 loads the entry pointer from bits 7:0 of the data and returns the phase to red, even in the middle of a triplet.
- R2: Byte stores (cpu_word low) to offset 0x4 take bits 7:0 and write red, green and blue of the current entry in that order, and the phase then returns to red.
- R3: After the blue byte is stored, the entry pointer increments and wraps from 255 to 0.
- R4: A 32-bit store (cpu_word high) to offset 0x4 is handled as four color bytes, bits 31:24 first and bits 7:0 last. Each byte advances the phase, and the pointer moves on inside the same store when a blue byte is reached.
- R5: cpu_rdata reads as zero at all offsets.
- R6: Any store to offset 0x4 sets redraw_req in the following cycle.
- R7: A redraw_ack pulse clears redraw_req in the following cycle, unless a store to offset 0x4 happens in the same cycle, in which case redraw_req stays set.
- R8: Reset sets every red, green and blue value to zero, the phase to red, the pointer to 0 and redraw_req to 1.
- R9: pix_rgb shows {red, green, blue} of entry pix_idx in bits 23:16, 15:8 and 7:0, one clock after pix_idx is sampled.
- R10: When a lookup and a store to the same entry happen in the same cycle, the lookup returns the value from before the store.
- R11: Stores to offsets other than 0x0 and 0x4 change neither the table, the pointer, the phase nor redraw_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register store strobe |
| cpu_word | input | 1 | 1: 32-bit store, 0: byte store |
| cpu_addr | input | 5 | Byte offset of the register |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Register read data (always zero) |
| redraw_ack | input | 1 | Display-side acknowledge of the redraw request |
| redraw_req | output | 1 | Full-frame redraw request |
| pix_idx | input | 8 | Scanout pixel index |
| pix_rgb | output | 24 | Scanout color {R,G,B}, one cycle latency |

## Verification
Byte stores that fill a whole triplet show that the phase order is red, green, blue and that the pointer moves after blue. A pointer reload in the middle of a triplet shows that the phase goes back to red. Two word stores that start at entry 254 check byte order and the wrap of the pointer to 0, and the second one starts at phase green, so it also shows that a single store can reach two entries. A lookup issued in the same cycle as a store to the same entry must return the old color. An acknowledge in the same cycle as a store, and a store to an unused offset, check when the redraw flag is allowed to change.

// File: rtl/palette_loader.sv
module palette_loader #(
  parameter int IDX_W = 8,
  parameter int CW    = 8,
  parameter int AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_word,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [4*CW-1:0]   cpu_wdata,
  output logic [4*CW-1:0]   cpu_rdata,
  input  logic              redraw_ack,
  output logic              redraw_req,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [3*CW-1:0]   pix_rgb
);
  localparam int N     = 1 << IDX_W;
  localparam int BYTES = 4;

  logic [CW-1:0]    red [N];
  logic [CW-1:0]    grn [N];
  logic [CW-1:0]    blu [N];
  logic [1:0]       phase;
  logic [IDX_W-1:0] index;

  logic [1:0]       ph_k [BYTES+1];
  logic [IDX_W-1:0] ix_k [BYTES+1];
  logic [CW-1:0]    bt   [BYTES];
  logic [BYTES-1:0] bv;

  wire idx_wr = cpu_wr && (cpu_addr == AW'(0));
  wire dat_wr = cpu_wr && (cpu_addr == AW'(4));

  assign cpu_rdata = '0;

  always_comb begin
    ph_k[0] = phase;
    ix_k[0] = index;
    for (int k = 0; k < BYTES; k++) begin
      bt[k] = cpu_word ? cpu_wdata[(BYTES-k)*CW-1 -: CW] : cpu_wdata[CW-1:0];
      bv[k] = dat_wr && (cpu_word || k == 0);
      if (bv[k]) begin
        ph_k[k+1] = (ph_k[k] == 2'd2) ? 2'd0 : ph_k[k] + 2'd1;
        ix_k[k+1] = (ph_k[k] == 2'd2) ? ix_k[k] + 1'b1 : ix_k[k];
      end else begin
        ph_k[k+1] = ph_k[k];
        ix_k[k+1] = ix_k[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin
        red[e] <= '0;
        grn[e] <= '0;
        blu[e] <= '0;
      end
      phase      <= 2'd0;
      index      <= '0;
      redraw_req <= 1'b1;
      pix_rgb    <= '0;
    end else begin
      pix_rgb <= {red[pix_idx], grn[pix_idx], blu[pix_idx]};
      if (idx_wr) begin
        index <= cpu_wdata[IDX_W-1:0];
        phase <= 2'd0;
      end else if (dat_wr) begin
        index <= ix_k[BYTES];
        phase <= ph_k[BYTES];
      end
      for (int k = 0; k < BYTES; k++) begin
        if (bv[k]) begin
          case (ph_k[k])
            2'd0:    red[ix_k[k]] <= bt[k];
            2'd1:    grn[ix_k[k]] <= bt[k];
            default: blu[ix_k[k]] <= bt[k];
          endcase
        end
      end
      redraw_req <= dat_wr | (redraw_req & ~redraw_ack);
    end
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (phase == 2'd0) && (index == $past(cpu_wdata[IDX_W-1:0])));

  // R2
  byte_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cpu_word) |=>
      phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cpu_word && phase == 2'd2) |=> index == $past(index) + 1'b1);

  // R4
  word_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cpu_word) |=>
      phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1));

  // R6
  redraw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> redraw_req);

  // R7
  redraw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_ack && !dat_wr) |=> !redraw_req);

  // R11
  other_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !dat_wr) |=> $stable(index) && $stable(phase));
endmodule

// File: tb/sim_palette_loader.sv
`timescale 1ns/1ps
module sim_palette_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_word = 1'b0;
  logic [4:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        redraw_ack = 1'b0;
  logic        redraw_req;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  palette_loader u0 (.*);

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx = 0;
  int         m_ph = 0;

  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        issue = 1'b0;
  int          pend = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void m_byte(logic [7:0] v);
    case (m_ph)
      0: m_r[m_idx] = v;
      1: m_g[m_idx] = v;
      default: begin m_b[m_idx] = v; m_idx = m_idx + 8'd1; end
    endcase
    m_ph = (m_ph == 2) ? 0 : m_ph + 1;
  endfunction

  function automatic void m_store(logic [4:0] a, logic [31:0] d, logic w);
    if (a == 5'd0) begin m_idx = d[7:0]; m_ph = 0; end
    else if (a == 5'd4) begin
      if (w) for (int k = 0; k < 4; k++) m_byte(d[31-8*k -: 8]);
      else m_byte(d[7:0]);
    end
  endfunction

  task automatic store(logic [4:0] a, logic [31:0] d, logic w);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_word = w;
    m_store(a, d, w);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic look(logic [7:0] i, string tag);
    @(negedge clk);
    pix_idx = i; issue = 1'b1;
    exp_q.push_back({m_r[i], m_g[i], m_b[i]});
    tag_q.push_back(tag);
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic store_and_look(logic [31:0] d, logic [7:0] i, string tag);
    @(negedge clk);
    pix_idx = i; issue = 1'b1;
    exp_q.push_back({m_r[i], m_g[i], m_b[i]});
    tag_q.push_back(tag);
    cpu_wr = 1'b1; cpu_addr = 5'd4; cpu_wdata = d; cpu_word = 1'b0;
    m_store(5'd4, d, 1'b0);
    @(negedge clk);
    cpu_wr = 1'b0; issue = 1'b0;
  endtask

  always @(posedge clk) if (issue) pend++;

  always @(negedge clk) begin
    #2;
    if (pend > 0) begin
      pend--;
      check(tag_q.pop_front(), {8'h0, pix_rgb}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    for (int e = 0; e < 256; e++) begin m_r[e] = 0; m_g[e] = 0; m_b[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 redraw after reset", {31'b0, redraw_req}, 32'd1);
    look(8'd0, "R8 entry 0 cleared");
    look(8'd255, "R8 entry 255 cleared");

    @(negedge clk); redraw_ack = 1'b1;
    @(negedge clk); redraw_ack = 1'b0; #1;
    check("R7 ack clears", {31'b0, redraw_req}, 32'd0);

    store(5'd0, 32'h0000_0005, 1'b0);
    store(5'd4, 32'h0000_0011, 1'b0); #1;
    check("R6 redraw set", {31'b0, redraw_req}, 32'd1);
    store(5'd4, 32'h0000_0022, 1'b0);
    store(5'd4, 32'h0000_0033, 1'b0);
    look(8'd5, "R2 R9 triplet order");
    store(5'd4, 32'h0000_0044, 1'b0);
    look(8'd6, "R3 pointer advanced");
    store(5'd0, 32'hFFFF_FF06, 1'b0);
    store(5'd4, 32'h0000_0055, 1'b0);
    look(8'd6, "R1 phase back to red");

    @(negedge clk); cpu_addr = 5'd0; #1;
    check("R5 rdata offset 0", cpu_rdata, 32'd0);
    @(negedge clk); cpu_addr = 5'd4; #1;
    check("R5 rdata offset 4", cpu_rdata, 32'd0);

    store(5'd0, 32'h0000_00FE, 1'b1);
    store(5'd4, 32'hA1B2_C3D4, 1'b1);
    store(5'd4, 32'hE5F6_0718, 1'b1);
    look(8'd254, "R4 word order entry 254");
    look(8'd255, "R4 word spans entry 255");
    look(8'd0, "R3 R4 wrap to entry 0");

    store_and_look(32'h0000_0099, 8'd0, "R10 same-cycle old value");
    look(8'd0, "R10 new value after");

    @(negedge clk); redraw_ack = 1'b1;
    cpu_wr = 1'b1; cpu_addr = 5'd4; cpu_wdata = 32'h0000_0077; cpu_word = 1'b0;
    m_store(5'd4, 32'h0000_0077, 1'b0);
    @(negedge clk); redraw_ack = 1'b0; cpu_wr = 1'b0; #1;
    check("R7 write wins over ack", {31'b0, redraw_req}, 32'd1);
    @(negedge clk); redraw_ack = 1'b1;
    @(negedge clk); redraw_ack = 1'b0;

    store(5'd8, 32'hFFFF_FFFF, 1'b1); #1;
    check("R11 redraw unchanged", {31'b0, redraw_req}, 32'd0);
    store(5'd4, 32'h0000_0066, 1'b0);
    look(8'd1, "R11 phase and table unchanged");
    look(8'd2, "R11 entry 2 untouched");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule